// File: doc/BRIEF.md
# Bus interrupt priority arbiter

This block gathers every interrupt source that can reach the processor and reports, in the same cycle, the single level the processor should take given its current priority level. The sources are a halt pin, a latched memory-error flag, four banks of 32 sticky device request lines, and a 16-bit summary of pending software interrupts. The winning level is zero when nothing qualifies.

When the processor takes an interrupt, it drives an acknowledge together with the level it took. On the next clock edge the arbiter clears the request it served and registers a vector for it. For a device level, the served request is the lowest-numbered pending line of that bank. Its vector comes from a per-source pair of configuration words: a base value and a set of forced bits. A memory-error acknowledge returns a fixed vector and drops the flag. An acknowledge at a level that no source can use is reported as an error.

A two-state machine frames the response. The machine starts in `ST_IDLE`. An acknowledge moves it to `ST_VEC`, and another acknowledge keeps it there. A cycle without an acknowledge returns it to `ST_IDLE`. The vector outputs are valid only in `ST_VEC`.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset all device request banks and the memory-error flag are clear, `win_level_o` is 0 with no sources active, and `vec_valid_o` is 0.
- R2: While `halt_i` is high, `win_level_o` is 0x1F regardless of every other input.
- R3: A pending memory error gives level 0x1D, but only while `cur_ipl_i` is below 0x1D.
- R4: Device levels are examined from 0x17 down to 0x14, where bank b is level 0x14+b. The first level above `cur_ipl_i` with any pending line wins. The search yields 0 as soon as the level under test is at or below `cur_ipl_i`.
- R5: Bit n of `sw_pend_i` requests software level n, for n from 1 to 15. Only bits above `cur_ipl_i` count, and the highest of them wins. Software levels are never chosen while `cur_ipl_i` is 15 or more, and bit 0 has no effect.
- R6: A one-cycle pulse on line i of bank b (`req_i[b*32+i]`) leaves that request pending until it is acknowledged.
- R7: An acknowledge at device level L clears the lowest-numbered pending line of bank L-0x14. In the following cycle `vec_valid_o` is high, and it is low in any cycle after one with no acknowledge.
- R8: For device source index s = b*32+i, the vector is (base|set) & (set|0x01FC). Here base and set are the words last written to entry s through `cfg_we_i`.
- R9: An acknowledge at level 0x1D returns vector 0x0060 with no error and clears the memory-error flag.
- R10: An acknowledge at a level above 0x17 other than 0x1D raises `ack_err_o` with vector 0 and clears no request.
- R11: An acknowledge at a device level whose bank has nothing pending returns vector 0 with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 1 | Halt pin |
| memerr_i | input | 1 | Pulse that sets the memory-error flag |
| req_i | input | 128 | Device request set pulses, bank b line i at bit b*32+i |
| sw_pend_i | input | 16 | Software interrupt summary, bit n for level n |
| cur_ipl_i | input | 5 | Processor's current priority level |
| cfg_we_i | input | 1 | Configuration entry write strobe |
| cfg_idx_i | input | 7 | Source index written |
| cfg_base_i | input | 16 | Base vector for the entry |
| cfg_set_i | input | 16 | Forced vector bits for the entry |
| ack_i | input | 1 | Interrupt acknowledge |
| ack_level_i | input | 5 | Level being acknowledged |
| win_level_o | output | 5 | Highest eligible level, 0 for none |
| vec_o | output | 16 | Vector of the last acknowledge |
| vec_valid_o | output | 1 | Vector outputs valid this cycle |
| ack_err_o | output | 1 | Last acknowledge named an unusable level |

## Verification
The properties assume that the current priority level and halt pin are stable between clock edges. They also assume that an acknowledge names a level and is held for exactly the cycle it should be sampled in. The memory-error assumption is weaker: a flag raised and acknowledged in the same cycle stays set. The stimulus changes inputs only on falling edges and holds each acknowledge for one cycle. It never pulses a request or memory error in the same cycle as the acknowledge that would clear it, so each expected vector depends on one well-defined request state.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int          LVL_W      = 5;
    localparam int          NUM_BANKS  = 4;
    localparam int          SW_W       = 16;
    localparam logic [4:0]  LVL_HALT   = 5'h1F;
    localparam logic [4:0]  LVL_MEMERR = 5'h1D;
    localparam logic [4:0]  LVL_HW_MIN = 5'h14;
    localparam logic [4:0]  LVL_HW_MAX = 5'h17;
    localparam logic [4:0]  LVL_SW_MAX = 5'h0F;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_VEC  = 1'b1
    } ack_state_e;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int LINES  = 32,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  set_i,
    input  logic              clr_en_i,
    output logic              any_o,
    output logic [LINE_W-1:0] low_idx_o
);
    logic [LINES-1:0] pend_q;
    logic [LINES-1:0] clr_mask;

    // lowest-numbered pending line
    always_comb begin
        low_idx_o = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend_q[i]) low_idx_o = LINE_W'(i);
        end
    end

    assign any_o    = |pend_q;
    assign clr_mask = clr_en_i ? (LINES'(1) << low_idx_o) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | set_i;
    end
endmodule

// File: rtl/irq_vec_cfg.sv
module irq_vec_cfg #(
    parameter int SRC   = 128,
    parameter int SRC_W = $clog2(SRC),
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [SRC_W-1:0] widx_i,
    input  logic [VEC_W-1:0] wbase_i,
    input  logic [VEC_W-1:0] wset_i,
    input  logic [SRC_W-1:0] ridx_i,
    output logic [VEC_W-1:0] rbase_o,
    output logic [VEC_W-1:0] rset_o
);
    logic [VEC_W-1:0] base_q [SRC];
    logic [VEC_W-1:0] set_q  [SRC];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SRC; s++) begin
                base_q[s] <= '0;
                set_q[s]  <= '0;
            end
        end else if (we_i) begin
            base_q[widx_i] <= wbase_i;
            set_q[widx_i]  <= wset_i;
        end
    end

    assign rbase_o = base_q[ridx_i];
    assign rset_o  = set_q[ridx_i];
endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
    import irq_arb_pkg::*;
(
    input  logic                 halt_i,
    input  logic                 memerr_i,
    input  logic [LVL_W-1:0]     ipl_i,
    input  logic [NUM_BANKS-1:0] bank_any_i,
    input  logic [SW_W-1:0]      sw_i,
    output logic [LVL_W-1:0]     level_o
);
    logic stop;

    always_comb begin
        level_o = '0;
        stop    = 1'b0;
        if (halt_i) begin
            level_o = LVL_HALT;
        end else if (memerr_i && (ipl_i < LVL_MEMERR)) begin
            level_o = LVL_MEMERR;
        end else begin
            for (int b = NUM_BANKS - 1; b >= 0; b--) begin
                if (!stop) begin
                    if ((LVL_HW_MIN + LVL_W'(b)) <= ipl_i) begin
                        stop = 1'b1;
                    end else if (bank_any_i[b]) begin
                        level_o = LVL_HW_MIN + LVL_W'(b);
                        stop    = 1'b1;
                    end
                end
            end
            if (!stop && (ipl_i < LVL_SW_MAX)) begin
                // ascending scan: the highest eligible bit is written last
                for (int s = 0; s < SW_W; s++) begin
                    if (sw_i[s] && (s > int'(ipl_i))) level_o = LVL_W'(s);
                end
            end
        end
    end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_arb_pkg::*;
#(
    parameter int               LINES      = 32,
    parameter int               VEC_W      = 16,
    parameter logic [VEC_W-1:0] VEC_KEEP   = 16'h01FC,
    parameter logic [VEC_W-1:0] MEMERR_VEC = 16'h0060,
    localparam int              LINE_W     = $clog2(LINES),
    localparam int              BANK_W     = $clog2(NUM_BANKS),
    localparam int              SRC        = NUM_BANKS * LINES,
    localparam int              SRC_W      = BANK_W + LINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             memerr_i,
    input  logic [SRC-1:0]   req_i,
    input  logic [SW_W-1:0]  sw_pend_i,
    input  logic [LVL_W-1:0] cur_ipl_i,
    input  logic             cfg_we_i,
    input  logic [SRC_W-1:0] cfg_idx_i,
    input  logic [VEC_W-1:0] cfg_base_i,
    input  logic [VEC_W-1:0] cfg_set_i,
    input  logic             ack_i,
    input  logic [LVL_W-1:0] ack_level_i,
    output logic [LVL_W-1:0] win_level_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_valid_o,
    output logic             ack_err_o
);
    ack_state_e              state_q, state_d;
    logic                    memerr_q;
    logic [NUM_BANKS-1:0]    bank_any;
    logic [LINE_W-1:0]       low_idx [NUM_BANKS];
    logic                    ack_hw, ack_mem, ack_bad;
    logic [BANK_W-1:0]       bank_sel;
    logic [VEC_W-1:0]        sel_base, sel_set, merged;
    logic [VEC_W-1:0]        vec_q;
    logic                    err_q;

    assign ack_hw   = ack_i && (ack_level_i >= LVL_HW_MIN) && (ack_level_i <= LVL_HW_MAX);
    assign ack_mem  = ack_i && (ack_level_i == LVL_MEMERR);
    assign ack_bad  = ack_i && (ack_level_i > LVL_HW_MAX) && (ack_level_i != LVL_MEMERR);
    assign bank_sel = BANK_W'(ack_level_i - LVL_HW_MIN);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irq_req_bank #(.LINES(LINES), .LINE_W(LINE_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (req_i[b*LINES +: LINES]),
            .clr_en_i (ack_hw && (bank_sel == BANK_W'(b))),
            .any_o    (bank_any[b]),
            .low_idx_o(low_idx[b])
        );
    end

    irq_vec_cfg #(.SRC(SRC), .SRC_W(SRC_W), .VEC_W(VEC_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .widx_i (cfg_idx_i),
        .wbase_i(cfg_base_i),
        .wset_i (cfg_set_i),
        .ridx_i ({bank_sel, low_idx[bank_sel]}),
        .rbase_o(sel_base),
        .rset_o (sel_set)
    );

    irq_level_eval u_eval (
        .halt_i    (halt_i),
        .memerr_i  (memerr_q),
        .ipl_i     (cur_ipl_i),
        .bank_any_i(bank_any),
        .sw_i      (sw_pend_i),
        .level_o   (win_level_o)
    );

    assign merged = (sel_base | sel_set) & (sel_set | VEC_KEEP);

    always_ff @(posedge clk) begin
        if (!rst_n) memerr_q <= 1'b0;
        else        memerr_q <= (memerr_q && !ack_mem) || memerr_i;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ack_i ? ST_VEC : ST_IDLE;
            ST_VEC:  state_d = ack_i ? ST_VEC : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            err_q <= 1'b0;
        end else if (ack_i) begin
            err_q <= ack_bad;
            if (ack_mem)     vec_q <= MEMERR_VEC;
            else if (ack_hw) vec_q <= bank_any[bank_sel] ? merged : '0;
            else             vec_q <= '0;
        end
    end

    assign vec_valid_o = (state_q == ST_VEC);
    assign vec_o       = vec_q;
    assign ack_err_o   = vec_valid_o && err_q;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
    import irq_arb_pkg::*;
#(
    parameter int               VEC_W      = 16,
    parameter logic [VEC_W-1:0] MEMERR_VEC = 16'h0060
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt_i,
    input logic [LVL_W-1:0] cur_ipl_i,
    input logic             ack_i,
    input logic [LVL_W-1:0] ack_level_i,
    input logic [LVL_W-1:0] win_level_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             vec_valid_o,
    input logic             ack_err_o
);
    p_halt_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |-> win_level_o == LVL_HALT);

    p_memerr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && win_level_o == LVL_MEMERR) |-> cur_ipl_i < LVL_MEMERR);

    p_above_ipl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && win_level_o != '0) |-> win_level_o > cur_ipl_i);

    p_sw_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && cur_ipl_i >= LVL_SW_MAX && win_level_o != '0) |-> win_level_o >= LVL_HW_MIN);

    p_ack_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> vec_valid_o);

    p_no_ack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !vec_valid_o && !ack_err_o);

    p_memerr_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ack_level_i == LVL_MEMERR) |=> (vec_o == MEMERR_VEC) && !ack_err_o);

    p_bad_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ack_level_i > LVL_HW_MAX && ack_level_i != LVL_MEMERR)
        |=> ack_err_o && (vec_o == '0));
endmodule

bind irq_prio_arb irq_arb_chk #(.VEC_W(VEC_W), .MEMERR_VEC(MEMERR_VEC)) u_chk (.*);

// File: tb/irq_prio_arb_tb.sv
`timescale 1ns/1ps
module irq_prio_arb_tb;
    localparam int LINES = 32;
    localparam int SRC   = 4 * LINES;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_i = 1'b0, memerr_i = 1'b0;
    logic [SRC-1:0] req_i = '0;
    logic [15:0] sw_pend_i = '0;
    logic [4:0]  cur_ipl_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [6:0]  cfg_idx_i = '0;
    logic [15:0] cfg_base_i = '0, cfg_set_i = '0;
    logic        ack_i = 1'b0;
    logic [4:0]  ack_level_i = '0;
    logic [4:0]  win_level_o;
    logic [15:0] vec_o;
    logic        vec_valid_o, ack_err_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    typedef struct { logic [15:0] vec; logic err; string tag; } exp_t;
    exp_t exp_q[$];

    logic [15:0] m_base [SRC];
    logic [15:0] m_set  [SRC];
    logic [31:0] m_req  [4];

    always #2.5 clk = ~clk;

    irq_prio_arb u_dut (.*);

    task automatic check_lvl(string tag, logic [4:0] exp);
        #1;
        checks++;
        if (win_level_o !== exp) begin
            errors++;
            $display("FAIL %s win_level actual=%h expected=%h", tag, win_level_o, exp);
        end
    endtask

    task automatic cfg_write(int idx, logic [15:0] b, logic [15:0] s);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_idx_i = 7'(idx); cfg_base_i = b; cfg_set_i = s;
        m_base[idx] = b; m_set[idx] = s;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic pulse_req(int bank, int line);
        @(negedge clk);
        req_i[bank*LINES + line] = 1'b1;
        m_req[bank][line] = 1'b1;
        @(negedge clk);
        req_i = '0;
    endtask

    // driver: push the expected response, then drive the acknowledge
    task automatic do_ack(string tag, logic [4:0] lvl);
        exp_t e;
        int b;
        e.tag = tag; e.vec = '0; e.err = 1'b0;
        if (lvl == 5'h1D) e.vec = 16'h0060;
        else if (lvl > 5'h17) e.err = 1'b1;
        else if (lvl >= 5'h14) begin
            b = int'(lvl) - 'h14;
            for (int i = LINES - 1; i >= 0; i--) begin
                if (m_req[b][i]) e.vec = (m_base[b*LINES+i] | m_set[b*LINES+i])
                                         & (m_set[b*LINES+i] | 16'h01FC);
            end
            for (int i = 0; i < LINES; i++) begin
                if (m_req[b][i]) begin m_req[b][i] = 1'b0; break; end
            end
        end
        @(negedge clk);
        exp_q.push_back(e);
        ack_i = 1'b1; ack_level_i = lvl;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    // monitor: compare each valid response against the queue head
    always @(negedge clk) begin
        #1;
        if (rst_n && vec_valid_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected vector actual=%h expected=none", vec_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (vec_o !== e.vec || ack_err_o !== e.err) begin
                    errors++;
                    $display("FAIL %s vec/err actual=%h/%b expected=%h/%b",
                             e.tag, vec_o, ack_err_o, e.vec, e.err);
                end
            end
        end
    end

    initial begin
        for (int b = 0; b < 4; b++) m_req[b] = '0;
        for (int s = 0; s < SRC; s++) begin m_base[s] = '0; m_set[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_lvl("R1 reset", 5'h00);
        checks++;
        if (vec_valid_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 vec_valid actual=%b expected=0", vec_valid_o);
        end

        cfg_write(5,        16'h0123, 16'h0000);
        cfg_write(9,        16'h0040, 16'h8003);
        cfg_write(3*32 + 2, 16'hFFFF, 16'h0001);

        // R5 software levels
        @(negedge clk); sw_pend_i = 16'h0089; cur_ipl_i = 5'd0;
        check_lvl("R5 highest sw bit", 5'd7);
        @(negedge clk); cur_ipl_i = 5'd5;
        check_lvl("R5 above ipl", 5'd7);
        @(negedge clk); cur_ipl_i = 5'd7;
        check_lvl("R5 none above ipl", 5'd0);
        @(negedge clk); sw_pend_i = 16'h0001; cur_ipl_i = 5'd0;
        check_lvl("R5 bit0 ignored", 5'd0);
        @(negedge clk); sw_pend_i = 16'h8000; cur_ipl_i = 5'd14;
        check_lvl("R5 level 15", 5'd15);
        @(negedge clk); cur_ipl_i = 5'd15;
        check_lvl("R5 blocked at 15", 5'd0);
        @(negedge clk); sw_pend_i = '0; cur_ipl_i = 5'd0;

        // R6 / R4 device levels
        pulse_req(0, 9);
        pulse_req(0, 5);
        check_lvl("R6 sticky request", 5'h14);
        @(negedge clk); sw_pend_i = 16'h0100; cur_ipl_i = 5'h14;
        check_lvl("R4 stop at ipl", 5'h00);
        @(negedge clk); sw_pend_i = '0;
        pulse_req(3, 2);
        @(negedge clk); cur_ipl_i = 5'h15;
        check_lvl("R4 top bank wins", 5'h17);
        @(negedge clk); cur_ipl_i = 5'h17;
        check_lvl("R4 top bank at ipl", 5'h00);

        // R3 memory error
        @(negedge clk); memerr_i = 1'b1;
        @(negedge clk); memerr_i = 1'b0; cur_ipl_i = 5'h18;
        check_lvl("R3 memerr below", 5'h1D);
        @(negedge clk); cur_ipl_i = 5'h1D;
        check_lvl("R3 memerr at level", 5'h00);

        // R2 halt
        @(negedge clk); halt_i = 1'b1; cur_ipl_i = 5'h1F;
        check_lvl("R2 halt wins", 5'h1F);
        @(negedge clk); halt_i = 1'b0; cur_ipl_i = 5'd0;

        // R7 / R8 device acknowledges
        check_lvl("R3 memerr beats device", 5'h1D);
        do_ack("R8 bank3 line2", 5'h17);
        do_ack("R8 bank0 line5", 5'h14);
        @(negedge clk); cur_ipl_i = 5'h18;
        check_lvl("R9 memerr still pending", 5'h1D);
        do_ack("R9 memerr vector", 5'h1D);
        @(negedge clk); cur_ipl_i = 5'd0;
        check_lvl("R7 next lowest remains", 5'h14);

        // R10 unusable level leaves requests alone
        do_ack("R10 bad level", 5'h1E);
        @(negedge clk);
        check_lvl("R10 nothing cleared", 5'h14);
        do_ack("R8 bank0 line9", 5'h14);
        @(negedge clk);
        check_lvl("R7 bank cleared", 5'h00);
        do_ack("R11 empty bank", 5'h14);
        do_ack("R11 empty bank3", 5'h17);
        repeat (3) @(negedge clk);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7 missing responses actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule